// File: doc/BRIEF.md
# Sleep-Tick Watchdog Reset

This block is a watchdog that counts interrupt pulses from a periodic sleep timer. It issues a one-cycle reset pulse when software does not service it in time. It runs on a 32 kHz clock. It contains a small sleep-timer prescaler, so it can be exercised without the rest of the system. The prescaler divides the clock by 8, 16, 32 or 64 and emits a one-cycle tick at each wrap.

After a power-on or external reset, a flag reads 1 and the watchdog is idle. Software arms the watchdog by clearing that flag through the control address. The flag cannot be set again by software, so arming is one-way until the next power-on or external reset. A reset raised by the watchdog itself leaves the flag clear, so the watchdog stays armed after it.

While armed, each sleep tick advances a 2-bit count. When the count reaches three, the terminal count is captured on the falling clock edge, which drives the reset output high for one clock period. Software services the watchdog with any write to the clear address. A write of 38h to that address also restarts the prescaler, which makes the next timeout exactly three intervals. Any other data leaves the prescaler running, so the timeout falls between just over two and three intervals.

Top module: `sleep_watchdog`

## Requirements
- R1: After power-on or external reset, `rst_flag_o` reads 1. While it is 1, the count stays at 0 and `wdr_o` never rises, however many sleep ticks occur.
- R2: A write to the control address (E0h) with data bit 0 at 0 clears `rst_flag_o`, which arms the watchdog. A write with bit 0 at 1 leaves the flag unchanged. Once clear, the flag stays clear until a power-on or external reset.
- R3: `sleep_tick_o` is high for one cycle every 8 << `sel_i` clock cycles (sel 0..3 gives 8, 16, 32, 64). It is first high in cycle 8 << `sel_i` after the prescaler restarts.
- R4: While armed, each sleep tick adds one to the count. When the count is 3, `wdr_o` rises at the following falling edge. It stays high for exactly one clock period.
- R5: Any write to the clear address (E3h) returns the count to 0, whatever the data. If a sleep tick falls in the same cycle as the write, the clear wins.
- R6: A write of 38h to E3h also restarts the prescaler and pulses `sleep_clr_o` in the write cycle. `wdr_o` is then first seen high 3·D+2 cycles after the write cycle, where D = 8 << `sel_i`.
- R7: A clear with data other than 38h leaves the prescaler running. Written in a tick cycle, it gives a timeout of 3·D+2 cycles. Written one cycle before a tick, it gives 2·D+3 cycles.
- R8: A watchdog reset zeroes the count and the prescaler but leaves `rst_flag_o` at 0. Without servicing, the next pulse is first seen 3·D+1 cycles after the previous one.
- R9: `rst_ni` or `xrst_ni` low asynchronously clears `wdr_o` and the count, and sets `rst_flag_o` to 1 (idle again).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32 kHz clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| xrst_ni | input | 1 | External reset, active low, asynchronous |
| sel_i | input | 2 | Sleep interval select, divide by 8 << sel_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| sleep_tick_o | output | 1 | Sleep-timer interrupt pulse |
| sleep_clr_o | output | 1 | Sleep-timer restart pulse (38h written to the clear address) |
| rst_flag_o | output | 1 | 1 = idle after power-on or external reset |
| wdr_o | output | 1 | Watchdog reset pulse |

## Verification
The bench measures the exact timeout for a clear written in a tick cycle, one cycle before a tick, and as 38h mid-interval.
- A design that let the tick win over a same-cycle clear would time out one interval early.
- A design that restarted the prescaler on every clear would give 3·D+2 where 2·D+3 is expected.

It checks that the flag survives a watchdog reset and that the pulse lasts exactly one period. A design that cleared the capture flop or the flag on its own reset would give a short pulse or fall idle.

It also checks that an unarmed block stays quiet. Before arming and after each power-on or external reset, a count that ran while idle would fire a reset.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam logic [7:0] ADDR_CTRL_DEF = 8'hE0;
  localparam logic [7:0] ADDR_CLR_DEF  = 8'hE3;
  localparam logic [7:0] SLEEP_KEY_DEF = 8'h38;

  typedef struct packed {
    logic       en;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_req_t;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int unsigned DIV_BASE = 8,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = $clog2(DIV_BASE) + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, limit;

  always_comb limit = CNT_W'((DIV_BASE << sel_i) - 1);

  // >= so a lowered select mid-interval wraps at once
  assign tick_o = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/swd_regs.sv
module swd_regs
  import swd_pkg::*;
#(
  parameter logic [7:0]  ADDR_CTRL = ADDR_CTRL_DEF,
  parameter logic [7:0]  ADDR_CLR  = ADDR_CLR_DEF,
  parameter logic [7:0]  SLEEP_KEY = SLEEP_KEY_DEF,
  parameter int unsigned FLAG_BIT  = 0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_req_t wr_i,
  output logic    flag_o,
  output logic    wd_clr_o,
  output logic    sleep_clr_o
);
  logic ctrl_hit, clr_hit;

  assign ctrl_hit    = wr_i.en && (wr_i.addr == ADDR_CTRL);
  assign clr_hit     = wr_i.en && (wr_i.addr == ADDR_CLR);
  assign wd_clr_o    = clr_hit;
  assign sleep_clr_o = clr_hit && (wr_i.data == SLEEP_KEY);

  // flag can only fall under software control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_o <= 1'b1;
    else if (ctrl_hit && !wr_i.data[FLAG_BIT]) flag_o <= 1'b0;
  end
endmodule

// File: rtl/swd_core.sv
module swd_core #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wdr_o
);
  localparam logic [CNT_W-1:0] TC_VAL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             tc, wdr_q;

  assign tc    = (cnt_q == TC_VAL);
  assign cnt_o = cnt_q;
  assign wdr_o = wdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i || clr_i || wdr_q)  cnt_q <= '0;
    else if (tick_i && !tc)            cnt_q <= cnt_q + 1'b1;
  end

  // falling-edge capture; only hard resets clear it, never its own pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdr_q <= 1'b0;
    else         wdr_q <= tc;
  end
endmodule

// File: rtl/sleep_watchdog.sv
module sleep_watchdog
  import swd_pkg::*;
#(
  parameter int unsigned DIV_BASE  = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned CNT_W     = 2,
  parameter logic [7:0]  ADDR_CTRL = ADDR_CTRL_DEF,
  parameter logic [7:0]  ADDR_CLR  = ADDR_CLR_DEF,
  parameter logic [7:0]  SLEEP_KEY = SLEEP_KEY_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xrst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic             sleep_tick_o,
  output logic             sleep_clr_o,
  output logic             rst_flag_o,
  output logic             wdr_o
);
  logic             hard_rst_n;
  wr_req_t          wr_req;
  logic             wd_clr, ps_clr;
  logic [CNT_W-1:0] wd_cnt;

  assign hard_rst_n = rst_ni & xrst_ni;
  assign wr_req     = '{en: wr_en_i, addr: wr_addr_i, data: wr_data_i};
  assign ps_clr     = sleep_clr_o | wdr_o;

  swd_regs #(
    .ADDR_CTRL(ADDR_CTRL), .ADDR_CLR(ADDR_CLR), .SLEEP_KEY(SLEEP_KEY), .FLAG_BIT(0)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(hard_rst_n), .wr_i(wr_req),
    .flag_o(rst_flag_o), .wd_clr_o(wd_clr), .sleep_clr_o(sleep_clr_o)
  );

  swd_prescaler #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_presc (
    .clk_i(clk_i), .rst_ni(hard_rst_n), .sel_i(sel_i),
    .clr_i(ps_clr), .tick_o(sleep_tick_o)
  );

  swd_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(hard_rst_n), .en_i(!rst_flag_o),
    .tick_i(sleep_tick_o), .clr_i(wd_clr), .cnt_o(wd_cnt), .wdr_o(wdr_o)
  );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int unsigned CNT_W    = 2,
  parameter logic [7:0]  ADDR_CLR = 8'hE3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xrst_ni,
  input logic             wr_en_i,
  input logic [7:0]       wr_addr_i,
  input logic             sleep_tick_o,
  input logic             sleep_clr_o,
  input logic             rst_flag_o,
  input logic             wdr_o,
  input logic [CNT_W-1:0] cnt_i
);
  logic hard_rst;
  assign hard_rst = !(rst_ni && xrst_ni);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (hard_rst)
    rst_flag_o |-> (cnt_i == '0 && !wdr_o));

  p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (hard_rst)
    !rst_flag_o |=> !rst_flag_o);

  p_tick_single_r3: assert property (@(posedge clk_i) disable iff (hard_rst)
    sleep_tick_o |=> !sleep_tick_o);

  p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (hard_rst)
    wdr_o |=> !wdr_o);

  p_pulse_from_tc_r4: assert property (@(posedge clk_i) disable iff (hard_rst)
    wdr_o |-> (cnt_i == '1));

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (hard_rst)
    (wr_en_i && wr_addr_i == ADDR_CLR) |=> (cnt_i == '0));

  p_sleep_restart_r6: assert property (@(posedge clk_i) disable iff (hard_rst)
    sleep_clr_o |=> !sleep_tick_o);

  p_self_reset_r8: assert property (@(posedge clk_i) disable iff (hard_rst)
    wdr_o |=> (cnt_i == '0 && !sleep_tick_o && !rst_flag_o));
endmodule

bind sleep_watchdog swd_checker #(.CNT_W(CNT_W), .ADDR_CLR(ADDR_CLR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xrst_ni(xrst_ni), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .sleep_tick_o(sleep_tick_o), .sleep_clr_o(sleep_clr_o),
  .rst_flag_o(rst_flag_o), .wdr_o(wdr_o), .cnt_i(wd_cnt)
);

// File: tb/test_sleep_watchdog.sv
`timescale 1ns/1ps
module test_sleep_watchdog;
  localparam logic [7:0] A_CTRL = 8'hE0;
  localparam logic [7:0] A_CLR  = 8'hE3;
  // {sel, mode, expected cycles write->first wdr}; mode 0: in tick cycle, 1: before tick, 2: 38h
  localparam int VEC [8][3] = '{
    '{0, 0, 26}, '{0, 1, 19}, '{0, 2, 26}, '{1, 1, 35},
    '{1, 2, 50}, '{2, 0, 98}, '{3, 1, 131}, '{3, 2, 194}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, xrst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       tick, sclr, flag, wdr;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_watchdog i_sleep_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .xrst_ni(xrst_n), .sel_i(sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sleep_tick_o(tick), .sleep_clr_o(sclr), .rst_flag_o(flag), .wdr_o(wdr)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic hard_reset(bit ext);
    if (ext) xrst_n = 1'b0; else rst_n = 1'b0;
    #0.5;
    check(flag == 1'b1 && wdr == 1'b0, "R9", "async reset flag/wdr", {flag, wdr}, 2);
    step(); step();
    rst_n = 1'b1; xrst_n = 1'b1;
    step();
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 200 && !tick; i++) step();
  endtask

  task automatic quiet(int cyc, string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (wdr) seen = 1'b1;
    end
    check(!seen, req, "no wdr while idle", seen, 0);
  endtask

  task automatic measure(output int n);
    n = 1;
    while (!wdr && n < 1000) begin step(); n++; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, d;
    step(); step();
    rst_n = 1'b1; xrst_n = 1'b1;
    step();
    check(flag == 1'b1, "R1", "flag after reset", flag, 1);
    check(wdr == 1'b0 && tick == 1'b0, "R1", "outputs after reset", {wdr, tick}, 0);

    // R3 period for two selects
    foreach (sel_list[k]) begin end
    for (int s = 0; s < 4; s += 2) begin
      sel = 2'(s);
      wait_tick(); step();
      n = 1;
      while (!tick && n < 200) begin step(); n++; end
      check(n == (8 << s), "R3", "tick period", n, 8 << s);
      step();
      check(!tick, "R3", "tick one cycle", tick, 0);
    end

    // R1/R2: idle stays quiet, bit0=1 does not arm
    sel = 2'd0;
    quiet(300, "R1");
    write(A_CTRL, 8'h01);
    check(flag == 1'b1, "R2", "bit0=1 leaves flag", flag, 1);
    quiet(60, "R2");

    for (int i = 0; i < 8; i++) begin
      hard_reset(i[0]);
      check(flag == 1'b1, "R9", "flag set by hard reset", flag, 1);
      sel = 2'(VEC[i][0]);
      d = 8 << VEC[i][0];
      write(A_CTRL, 8'hFE);
      check(flag == 1'b0, "R2", "armed", flag, 0);
      write(A_CTRL, 8'hFF);
      check(flag == 1'b0, "R2", "flag cannot be set", flag, 0);
      wait_tick();
      case (VEC[i][1])
        0: begin // R5: clear in tick cycle wins
          wr_en = 1'b1; wr_addr = A_CLR; wr_data = i[1] ? 8'h00 : 8'hA5;
          #0.5;
          check(sclr == 1'b0, "R6", "no sleep clear for other data", sclr, 0);
          step(); wr_en = 1'b0;
        end
        1: begin // R7: clear one cycle before tick
          for (int k = 0; k < d - 1; k++) step();
          check(tick == 1'b0, "R7", "pre-tick cycle", tick, 0);
          write(A_CLR, i[1] ? 8'h00 : 8'hC3);
        end
        default: begin // R6: 38h mid-interval
          step(); step(); step();
          wr_en = 1'b1; wr_addr = A_CLR; wr_data = 8'h38;
          #0.5;
          check(sclr == 1'b1, "R6", "sleep clear pulse", sclr, 1);
          step(); wr_en = 1'b0;
        end
      endcase
      measure(n);
      check(n == VEC[i][2], VEC[i][1] == 2 ? "R6" : (VEC[i][1] == 0 ? "R5" : "R7"),
            "timeout cycles", n, VEC[i][2]);
      check(flag == 1'b0, "R8", "flag kept through wdr", flag, 0);
      step();
      check(wdr == 1'b0, "R4", "pulse width one cycle", wdr, 0);
    end

    // R8: unserviced repeat after self reset, sel=3
    d = 64;
    n = 1;
    while (!wdr && n < 1000) begin step(); n++; end
    check(n == 3 * d + 1, "R8", "repeat pulse spacing", n, 3 * d + 1);
    check(flag == 1'b0, "R8", "still armed", flag, 0);

    // R9: power-on reset disarms
    hard_reset(1'b0);
    sel = 2'd0;
    check(flag == 1'b1, "R9", "POR disarms", flag, 1);
    quiet(300, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int sel_list [1];
endmodule